// File: doc/BRIEF.md
# Processor Status Flags and Branch Condition Unit

This block holds the eight-bit processor status word of a small CPU core. The low six bits are arithmetic condition flags, written after each ALU add from the two operands and the incoming carry. Bit 6 is a general user bit. Bit 7 is the master interrupt enable. The same word feeds two consumers. The branch logic tests any one bit against a chosen polarity. The interrupt path masks each source's request with the master enable.

The enable bit follows the interrupt sequence. Taking an interrupt clears it and returning from the handler sets it again. Single-bit set and clear commands can change any bit. Using them on bit 7 gives the enable-interrupts and disable-interrupts operations.

Software reaches the word through a memory-mapped port. It answers at one offset in the I/O window and at the same offset plus a fixed bias in the flat data space. The port is a plain single-cycle strobe with no back-pressure: a read returns data in the same cycle, and a write takes effect at the next clock edge.

Top module: `cpu_status_unit`

## Requirements
- R1: After reset all eight status bits read 0, so interrupts start disabled and no request is passed on.
- R2: When `alu_valid` is 1, the sum s = a + b + cin (9-bit) updates the flags at the next edge. Carry (bit 0) = s[8]. Zero (bit 1) = (s[7:0] == 0). Negative (bit 2) = s[7]. Bits 6 and 7 are left unchanged.
- R3: Overflow (bit 3) is 1 exactly when the signed sum of a, b and cin lies outside -128..127. Operands of opposite sign never set it.
- R4: After an ALU update, sign (bit 4) = negative XOR overflow, and half-carry (bit 5) is the carry out of the low nibble.
- R5: When `bit_valid` is 1, bit `bit_idx` becomes `bit_set`. This command overrides an ALU update of the same bit in the same cycle. Index 7 enables or disables interrupts.
- R6: `irq_enter` clears bit 7 and `reti` sets it. When both occur together, `irq_enter` wins, and both override a bit command on bit 7.
- R7: `irq_out[k]` = `irq_req[k]` AND `irq_mask[k]` AND bit 7, combinationally.
- R8: `br_taken` = (status[`br_idx`] == `br_pol`), combinationally. The branch-if-lower and branch-if-carry tests are both index 0 with polarity 1.
- R9: A bus access hits when `bus_io_space`=1 with address 0x3F, or when `bus_io_space`=0 with address 0x5F. A hit read returns the status word in `bus_rdata` in the same cycle. Any other access gives `bus_hit`=0 and `bus_rdata`=0.
- R10: A hit write replaces all eight bits with `bus_wdata` at the next edge, over every other update in that cycle. A write that misses has no effect.
- R11: In a cycle with no ALU update, bit command, interrupt event or hit write, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_valid | input | 1 | ALU add result present this cycle |
| alu_a | input | 8 | First add operand |
| alu_b | input | 8 | Second add operand |
| alu_cin | input | 1 | Carry into the add |
| bit_valid | input | 1 | Single-bit command strobe |
| bit_set | input | 1 | Value for the addressed bit |
| bit_idx | input | 3 | Index of the bit to change |
| irq_enter | input | 1 | Interrupt being taken |
| reti | input | 1 | Return from interrupt |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_io_space | input | 1 | 1 = I/O window address, 0 = data-space address |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 on a miss |
| bus_hit | output | 1 | Access decodes to the status word |
| irq_req | input | 4 | Per-source interrupt requests |
| irq_mask | input | 4 | Per-source enable mask |
| irq_out | output | 4 | Gated requests |
| br_idx | input | 3 | Bit tested by the branch |
| br_pol | input | 1 | Required bit value for taken |
| br_taken | output | 1 | Branch condition result |
| status | output | 8 | Current status word |

## Verification
The bench probes the signed-overflow edges: +127 plus 1, -128 plus -1, -128 plus -128, and mixed-sign pairs near the limits. A design that used the carry, or the raw sign of the result, as overflow would flag these wrongly.

It also makes events collide in one cycle: a software write with an ALU update and interrupt entry, interrupt entry with return, and a bit command with an ALU update of the same bit. A wrong priority order leaves a stale enable or flag.

Accesses go to both valid addresses and to the two swapped space/address pairs. A decoder that ignored the space select would answer at the wrong address.

A long mixed stream checks the branch output for every index and polarity against a model of the word. It also checks that the gated requests follow the enable bit.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
  localparam int W       = 8;
  localparam int IDX_W   = $clog2(W);
  localparam int B_CARRY = 0;
  localparam int B_ZERO  = 1;
  localparam int B_NEG   = 2;
  localparam int B_OVF   = 3;
  localparam int B_SIGN  = 4;
  localparam int B_HALF  = 5;
  localparam int B_USER  = 6;
  localparam int B_IEN   = 7;
  localparam int N_ALU_FLAGS = 6;

  typedef struct packed {
    logic half;
    logic sign;
    logic ovf;
    logic neg;
    logic zero;
    logic carry;
  } alu_flags_t;
endpackage

// File: rtl/cpu_status_flaggen.sv
module cpu_status_flaggen
  import cpu_status_pkg::*;
#(
  parameter int DW = W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output alu_flags_t    flags
);
  localparam int NIB = DW / 2;

  logic [DW:0]  full;
  logic [NIB:0] low;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    flags.carry = full[DW];
    flags.zero  = (full[DW-1:0] == '0);
    flags.neg   = full[DW-1];
    flags.ovf   = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
    flags.sign  = flags.neg ^ flags.ovf;
    flags.half  = low[NIB];
  end
endmodule

// File: rtl/cpu_status_addrdec.sv
module cpu_status_addrdec #(
  parameter int ADDR_W    = 16,
  parameter int IO_OFF    = 'h3F,
  parameter int DATA_BIAS = 'h20
) (
  input  logic              bus_valid,
  input  logic              bus_io_space,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] IO_ADDR   = ADDR_W'(IO_OFF);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(IO_OFF + DATA_BIAS);

  always_comb
    hit = bus_valid && (bus_io_space ? (bus_addr == IO_ADDR)
                                     : (bus_addr == DATA_ADDR));
endmodule

// File: rtl/cpu_status_core.sv
module cpu_status_core
  import cpu_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_valid,
  input  alu_flags_t       alu_flags,
  input  logic             bit_valid,
  input  logic             bit_set,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             irq_enter,
  input  logic             reti,
  input  logic             sw_write,
  input  logic [W-1:0]     sw_data,
  output logic [W-1:0]     q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (alu_valid) nxt[N_ALU_FLAGS-1:0] = alu_flags;
    if (bit_valid) nxt[bit_idx] = bit_set;
    if (reti)      nxt[B_IEN] = 1'b1;
    if (irq_enter) nxt[B_IEN] = 1'b0;
    if (sw_write)  nxt = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nxt;

  p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_write |=> q == $past(sw_data));
  p_irq_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !sw_write) |=> !q[B_IEN]);
  p_reti_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_enter && !sw_write) |=> q[B_IEN]);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_valid && !bit_valid && !irq_enter && !reti && !sw_write) |=> $stable(q));
  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && !bit_valid && !sw_write) |=> q[B_SIGN] == (q[B_NEG] ^ q[B_OVF]));
endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import cpu_status_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_OFF    = 'h3F,
  parameter int DATA_BIAS = 'h20,
  parameter int N_IRQ     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  input  logic [W-1:0]      alu_a,
  input  logic [W-1:0]      alu_b,
  input  logic              alu_cin,
  input  logic              bit_valid,
  input  logic              bit_set,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              irq_enter,
  input  logic              reti,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_io_space,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_hit,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_mask,
  output logic [N_IRQ-1:0]  irq_out,
  input  logic [IDX_W-1:0]  br_idx,
  input  logic              br_pol,
  output logic              br_taken,
  output logic [W-1:0]      status
);
  alu_flags_t flags;
  logic       hit;

  cpu_status_flaggen #(.DW(W)) u_flags (
    .a(alu_a), .b(alu_b), .cin(alu_cin), .flags(flags)
  );

  cpu_status_addrdec #(.ADDR_W(ADDR_W), .IO_OFF(IO_OFF), .DATA_BIAS(DATA_BIAS)) u_dec (
    .bus_valid(bus_valid), .bus_io_space(bus_io_space), .bus_addr(bus_addr), .hit(hit)
  );

  cpu_status_core u_core (
    .clk(clk), .rst_n(rst_n),
    .alu_valid(alu_valid), .alu_flags(flags),
    .bit_valid(bit_valid), .bit_set(bit_set), .bit_idx(bit_idx),
    .irq_enter(irq_enter), .reti(reti),
    .sw_write(hit && bus_write), .sw_data(bus_wdata),
    .q(status)
  );

  assign bus_hit   = hit;
  assign bus_rdata = (hit && !bus_write) ? status : '0;
  assign br_taken  = (status[br_idx] == br_pol);

  for (genvar k = 0; k < N_IRQ; k++) begin : g_gate
    assign irq_out[k] = irq_req[k] & irq_mask[k] & status[B_IEN];
  end

  always_comb
    if (rst_n) p_irq_gate_r7: assert ((irq_out == '0) || status[B_IEN]);
endmodule

// File: tb/cpu_status_unit_tb.sv
module cpu_status_unit_tb;
  logic clk = 0, rst_n = 0;
  logic alu_valid = 0, alu_cin = 0, bit_valid = 0, bit_set = 0;
  logic [7:0] alu_a = 0, alu_b = 0, bus_wdata = 0, bus_rdata, status;
  logic [2:0] bit_idx = 0, br_idx = 0;
  logic irq_enter = 0, reti = 0, bus_valid = 0, bus_write = 0, bus_io_space = 0;
  logic [15:0] bus_addr = 0;
  logic bus_hit, br_pol = 0, br_taken;
  logic [3:0] irq_req = 0, irq_mask = 0, irq_out;

  int errors = 0, checks = 0;
  logic [7:0] m;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  cpu_status_unit u_dut (.*);

  function automatic logic [5:0] addflags(logic [7:0] a, logic [7:0] b, logic c);
    int u, sg, lo;
    logic [5:0] f;
    u  = int'(a) + int'(b) + int'(c);
    sg = int'($signed(a)) + int'($signed(b)) + int'(c);
    lo = int'(a % 16) + int'(b % 16) + int'(c);
    f[0] = u > 255;
    f[1] = (u % 256) == 0;
    f[2] = (u % 256) >= 128;
    f[3] = (sg > 127) || (sg < -128);
    f[4] = f[2] ^ f[3];
    f[5] = lo > 15;
    return f;
  endfunction

  function automatic bit is_hit();
    return bus_valid && ((bus_io_space && bus_addr == 16'h3F) ||
                         (!bus_io_space && bus_addr == 16'h5F));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m = 8'h00;
    else begin
      logic [7:0] n;
      n = m;
      if (alu_valid) n[5:0] = addflags(alu_a, alu_b, alu_cin);
      if (bit_valid) n[bit_idx] = bit_set;
      if (reti) n[7] = 1'b1;
      if (irq_enter) n[7] = 1'b0;
      if (bus_write && is_hit()) n = bus_wdata;
      m = n;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] rd;
    chk(cur_req, status, m);
    chk("R8 branch", {7'd0, br_taken}, {7'd0, m[br_idx] == br_pol});
    chk("R7 irq gate", {4'd0, irq_out}, {4'd0, irq_req & irq_mask & {4{m[7]}}});
    rd = (is_hit() && !bus_write) ? m : 8'h00;
    chk("R9 bus read", bus_rdata, rd);
    chk("R9 bus hit", {7'd0, bus_hit}, {7'd0, is_hit()});
  endtask

  task automatic idle();
    alu_valid = 0; bit_valid = 0; irq_enter = 0; reti = 0; bus_valid = 0; bus_write = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic add(logic [7:0] a, logic [7:0] b, logic c);
    alu_valid = 1; alu_a = a; alu_b = b; alu_cin = c;
    step();
  endtask

  task automatic wr(bit io, logic [15:0] ad, logic [7:0] d);
    bus_valid = 1; bus_write = 1; bus_io_space = io; bus_addr = ad; bus_wdata = d;
    step();
  endtask

  task automatic rd_at(bit io, logic [15:0] ad);
    bus_valid = 1; bus_write = 0; bus_io_space = io; bus_addr = ad;
    @(negedge clk); compare();
    step();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    cur_req = "R1 reset"; compare();
    irq_req = 4'hF; irq_mask = 4'hF;
    compare();
    rst_n = 1;
    step();
    cur_req = "R2 add flags";
    add(8'h00, 8'h00, 0); add(8'hFF, 8'h01, 0); add(8'h80, 8'h7F, 1); add(8'h12, 8'h34, 0);
    cur_req = "R3 overflow";
    add(8'h7F, 8'h01, 0); add(8'h80, 8'hFF, 0); add(8'h80, 8'h80, 0);
    add(8'h7F, 8'h80, 1); add(8'h80, 8'h7F, 0); add(8'h01, 8'hFF, 0); add(8'h7E, 8'h01, 1);
    add(8'h7F, 8'hFF, 1); add(8'h81, 8'hFF, 0);
    cur_req = "R4 sign/half";
    add(8'h0F, 8'h01, 0); add(8'h08, 8'h07, 1); add(8'hC0, 8'hC0, 0);
    cur_req = "R5 bit cmd";
    bit_valid = 1; bit_idx = 7; bit_set = 1; step();
    bit_valid = 1; bit_idx = 6; bit_set = 1; step();
    bit_valid = 1; bit_idx = 0; bit_set = 0; alu_valid = 1; alu_a = 8'hFF; alu_b = 8'h01; alu_cin = 0; step();
    cur_req = "R6 irq seq";
    irq_enter = 1; step();
    reti = 1; step();
    irq_enter = 1; reti = 1; step();
    bit_valid = 1; bit_idx = 7; bit_set = 1; irq_enter = 1; step();
    bit_valid = 1; bit_idx = 7; bit_set = 0; reti = 1; step();
    cur_req = "R10 sw write";
    wr(1, 16'h3F, 8'h5A); wr(0, 16'h5F, 8'hA5);
    alu_valid = 1; alu_a = 8'h7F; alu_b = 8'h01; irq_enter = 1; reti = 1;
    wr(1, 16'h3F, 8'h81);
    wr(1, 16'h5F, 8'h00); wr(0, 16'h3F, 8'h00); wr(1, 16'h3E, 8'h00);
    cur_req = "R9 bus read";
    rd_at(1, 16'h3F); rd_at(0, 16'h5F); rd_at(0, 16'h3F); rd_at(1, 16'h5F); rd_at(0, 16'h015F);
    cur_req = "R11 hold";
    step(); step();
    cur_req = "R8 branch sweep";
    wr(0, 16'h5F, 8'h96);
    for (int i = 0; i < 16; i++) begin
      br_idx = 3'(i % 8); br_pol = i[3];
      @(negedge clk); compare();
    end
    br_idx = 0; br_pol = 1; @(negedge clk); compare();
    cur_req = "R5/R6/R10 mixed";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      alu_valid = r[0]; alu_a = 8'($urandom); alu_b = 8'($urandom); alu_cin = r[1];
      bit_valid = r[2] & r[3]; bit_idx = r[6:4]; bit_set = r[7];
      irq_enter = r[8] & r[9] & r[10]; reti = r[11] & r[12] & r[13];
      bus_valid = r[14]; bus_write = r[15]; bus_io_space = r[16];
      bus_addr = r[17] ? 16'h3F : (r[18] ? 16'h5F : 16'($urandom));
      bus_wdata = 8'($urandom); br_idx = r[21:19]; br_pol = r[22];
      irq_req = r[26:23]; irq_mask = r[30:27];
      @(negedge clk); compare();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule